// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt

This block is a free-running counter paired with a compare register. It raises a timer interrupt when the counter reaches the compare value. The counter advances by one on every cycle in which the tick-enable input is high and the halt input is low. Software can load the counter and the compare register through write strobes, and both values are always visible on readback outputs. A pending interrupt shows up on the status output. It also drives exactly one of the interrupt lines, and a select field chooses which line.

Only a write to the compare register acknowledges a pending interrupt. A three-state machine keeps a single match from firing twice. The states are ARMED, PEND and SPENT. From ARMED, a match seen while the counter is not halted and no compare write is present moves the machine to PEND. From PEND, a compare write moves it to SPENT. SPENT is the acknowledged state that waits for the counter to leave the compare value. From SPENT, the first cycle in which the counter differs from the compare value moves the machine back to ARMED.

Top module: `count_compare_timer`

## Requirements
- R1: Reset sets the count to 1 and the compare to 0. It also clears the pending status and all interrupt lines.
- R2: With no count write, the count increments by one on each clock edge where tick_en is 1 and count_halt is 0. With tick_en at 0 the count holds.
- R3: While count_halt is 1, the count holds even if tick_en is 1. A count equal to the compare value raises no interrupt while halted. It raises one on the first edge after the halt is removed.
- R4: A count write loads cnt_wr_data on the next edge. It takes precedence over incrementing and also applies while halted.
- R5: A compare write loads cmp_wr_data on the next edge, and compare_q reads it back.
- R6: The count wraps from 0xFFFFFFFF to 0 when it increments.
- R7: In ARMED, a cycle with count_q equal to compare_q, count_halt at 0 and no compare write sets timer_pend on the next edge. While timer_pend is 1, irq_lines bit number irq_sel is 1 and every other bit is 0. While timer_pend is 0, irq_lines is all zero.
- R8: A compare write clears timer_pend and lowers the interrupt line on the next edge. A compare write in the same cycle as a match suppresses that match.
- R9: After an acknowledgement, the interrupt does not fire again while the count stays equal to the compare. It re-arms once the count differs and fires on the next match.
- R10: While timer_pend is 1, a change of irq_sel moves the asserted line to the new index in the same cycle.
- R11: A count write and a compare write in the same cycle both load. The match test on the following cycle uses the two new values.
- R12: A pending interrupt stays set through count writes and counting. Only a compare write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance enable for this cycle |
| count_halt | input | 1 | Freezes the count and blocks match detection |
| irq_sel | input | 3 | Index of the interrupt line to drive |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 32 | Value for a count write |
| cmp_wr_en | input | 1 | Compare write strobe (also the acknowledge) |
| cmp_wr_data | input | 32 | Value for a compare write |
| count_q | output | 32 | Current count |
| compare_q | output | 32 | Current compare value |
| timer_pend | output | 1 | Timer interrupt pending |
| irq_lines | output | 8 | Interrupt lines, at most one high |

## Verification
The hardest situation to reach is SPENT: the interrupt has been acknowledged, but the count still equals the compare value. The stimulus gets there by stopping the ticks and then writing the compare register with the value the count already holds. It then keeps the count parked for several cycles to show that no second interrupt appears. After that it moves the count away, loads it back under the same compare value, and confirms that the interrupt fires again. A second hard case is a match that sits behind a halt. The stimulus parks the count on the compare value while halted, then releases the halt and watches the interrupt rise on the first edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_PEND  = 2'd1,
        ST_SPENT = 2'd2
    } arm_state_e;
endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         halt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_r;
    logic [W-1:0] count_nxt;

    // write beats increment; increment wraps modulo 2^W
    always_comb begin
        if (wr_en)
            count_nxt = wr_data;
        else if (tick && !halt)
            count_nxt = count_r + ONE;
        else
            count_nxt = count_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_r <= RESET_VAL;
        else
            count_r <= count_nxt;
    end

    assign count = count_r;
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] count,
    output logic [W-1:0] compare,
    output logic         match
);
    logic [W-1:0] cmp_r;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_r <= '0;
        else if (wr_en)
            cmp_r <= wr_data;
    end

    assign compare = cmp_r;
    assign match   = (count == cmp_r);
endmodule

// File: rtl/cc_irq_fsm.sv
module cc_irq_fsm
    import cc_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic halt,
    input  logic ack,
    output logic pend
);
    arm_state_e state_q;
    arm_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_ARMED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (match && !halt && !ack) state_d = ST_PEND;
            ST_PEND:  if (ack)                    state_d = ST_SPENT;
            ST_SPENT: if (!match)                 state_d = ST_ARMED;
            default:                              state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        pend = (state_q == ST_PEND);
    end
endmodule

// File: rtl/cc_irq_route.sv
module cc_irq_route #(
    parameter int LINES = 8,
    parameter int SEL_W = $clog2(LINES)
) (
    input  logic             pend,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = pend && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/count_compare_timer.sv
module count_compare_timer #(
    parameter int  CNT_W = 32,
    parameter int  LINES = 8,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             count_halt,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] compare_q,
    output logic             timer_pend,
    output logic [LINES-1:0] irq_lines
);
    logic match;

    cc_counter #(.W(CNT_W), .RESET_VAL(CNT_W'(1))) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .halt    (count_halt),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .count   (count_q)
    );

    cc_compare #(.W(CNT_W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .count   (count_q),
        .compare (compare_q),
        .match   (match)
    );

    cc_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .halt  (count_halt),
        .ack   (cmp_wr_en),
        .pend  (timer_pend)
    );

    cc_irq_route #(.LINES(LINES), .SEL_W(SEL_W)) u_route (
        .pend  (timer_pend),
        .sel   (irq_sel),
        .lines (irq_lines)
    );
endmodule

// File: rtl/cc_timer_checker.sv
module cc_timer_checker #(
    parameter int  CNT_W = 32,
    parameter int  LINES = 8,
    localparam int SEL_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             count_halt,
    input logic [SEL_W-1:0] irq_sel,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic             cmp_wr_en,
    input logic [CNT_W-1:0] cmp_wr_data,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] compare_q,
    input logic             timer_pend,
    input logic [LINES-1:0] irq_lines
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_en && tick_en && !count_halt) |=> (count_q == $past(count_q) + ONE));

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_en && count_halt) |=> $stable(count_q));

    p_halt_no_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_halt && !timer_pend) |=> !timer_pend);

    p_count_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (count_q == $past(cnt_wr_data)));

    p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_en |=> (compare_q == $past(cmp_wr_data)));

    p_lines_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_pend |-> (irq_lines == '0));

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_en |=> !timer_pend);

    p_line_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timer_pend |-> ($countones(irq_lines) == 1 && irq_lines[irq_sel]));

    p_pend_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_pend && !cmp_wr_en) |=> timer_pend);
endmodule

bind count_compare_timer cc_timer_checker #(.CNT_W(CNT_W), .LINES(LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .count_halt  (count_halt),
    .irq_sel     (irq_sel),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .count_q     (count_q),
    .compare_q   (compare_q),
    .timer_pend  (timer_pend),
    .irq_lines   (irq_lines)
);

// File: tb/test_count_compare_timer.sv
module test_count_compare_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        count_halt = 1'b0;
    logic [2:0]  irq_sel = 3'd0;
    logic        cnt_wr_en = 1'b0;
    logic [31:0] cnt_wr_data = '0;
    logic        cmp_wr_en = 1'b0;
    logic [31:0] cmp_wr_data = '0;
    logic [31:0] count_q;
    logic [31:0] compare_q;
    logic        timer_pend;
    logic [7:0]  irq_lines;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    count_compare_timer i_count_compare_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_halt(count_halt),
        .irq_sel(irq_sel), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data), .count_q(count_q),
        .compare_q(compare_q), .timer_pend(timer_pend), .irq_lines(irq_lines)
    );

    // row: cnt_wr, cnt_data, cmp_wr, cmp_data, tick, halt, sel | exp count, exp pend, exp lines
    localparam int NV = 16;
    localparam logic [111:0] VEC [NV] = '{
        {1'b0, 32'd0,   1'b1, 32'd5,   1'b1, 1'b0, 3'd2, 32'd2,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd2, 32'd3,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd2, 32'd4,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd2, 32'd5,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b0, 1'b0, 3'd2, 32'd5,   1'b1, 8'h04},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd6, 32'd6,   1'b1, 8'h40},
        {1'b0, 32'd0,   1'b1, 32'd6,   1'b0, 1'b0, 3'd6, 32'd6,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd6,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd6,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd6, 32'd7,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd7,   1'b0, 8'h00},
        {1'b1, 32'd5,   1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd5,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b1, 1'b0, 3'd6, 32'd6,   1'b0, 8'h00},
        {1'b0, 32'd0,   1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd6,   1'b1, 8'h40},
        {1'b1, 32'd100, 1'b0, 32'd0,   1'b0, 1'b0, 3'd6, 32'd100, 1'b1, 8'h40},
        {1'b0, 32'd0,   1'b1, 32'd200, 1'b1, 1'b0, 3'd6, 32'd101, 1'b0, 8'h00}
    };

    function automatic string row_tag(int i);
        case (i)
            0:       return "R5";
            1, 2, 3: return "R2";
            4:       return "R7";
            5:       return "R10";
            6, 15:   return "R8";
            11:      return "R4";
            12:      return "R2";
            14:      return "R12";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cnt_wr_en = 1'b0; cmp_wr_en = 1'b0; tick_en = 1'b0; count_halt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        check("R1", "reset count", count_q, 32'd1);
        check("R1", "reset compare", compare_q, 32'd0);
        check("R1", "reset pend", {31'd0, timer_pend}, 32'd0);
        check("R1", "reset lines", {24'd0, irq_lines}, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // table walk, starting from the reset state
        for (int i = 0; i < NV; i++) begin
            cnt_wr_en   = VEC[i][111];
            cnt_wr_data = VEC[i][110:79];
            cmp_wr_en   = VEC[i][78];
            cmp_wr_data = VEC[i][77:46];
            tick_en     = VEC[i][45];
            count_halt  = VEC[i][44];
            irq_sel     = VEC[i][43:41];
            step();
            idle_inputs();
            #1;
            check(row_tag(i), $sformatf("row %0d count", i), count_q, VEC[i][40:9]);
            check(row_tag(i), $sformatf("row %0d pend", i), {31'd0, timer_pend}, {31'd0, VEC[i][8]});
            check(row_tag(i), $sformatf("row %0d lines", i), {24'd0, irq_lines}, {24'd0, VEC[i][7:0]});
        end
        check("R5", "compare readback", compare_q, 32'd200);

        // R3: match parked behind a halt
        do_reset();
        irq_sel = 3'd3;
        count_halt = 1'b1; cmp_wr_en = 1'b1; cmp_wr_data = 32'd1; tick_en = 1'b1;
        step();
        cmp_wr_en = 1'b0;
        repeat (3) step();
        check("R3", "halted count", count_q, 32'd1);
        check("R3", "no pend while halted", {31'd0, timer_pend}, 32'd0);
        count_halt = 1'b0; tick_en = 1'b0;
        step();
        check("R3", "pend after halt release", {31'd0, timer_pend}, 32'd1);
        check("R7", "line 3 raised", {24'd0, irq_lines}, 32'h08);

        // R4: count write while halted
        count_halt = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 32'hFFFF_FFFF;
        step();
        idle_inputs();
        check("R4", "load while halted", count_q, 32'hFFFF_FFFF);
        check("R12", "pend kept over count write", {31'd0, timer_pend}, 32'd1);

        // R6: wrap
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
        check("R6", "wrap to zero", count_q, 32'd0);

        // ack, then re-arm
        cmp_wr_en = 1'b1; cmp_wr_data = 32'd1000;
        step();
        cmp_wr_en = 1'b0;
        check("R8", "ack clears pend", {31'd0, timer_pend}, 32'd0);
        step();

        // R11: simultaneous count and compare writes
        cnt_wr_en = 1'b1; cnt_wr_data = 32'd50; cmp_wr_en = 1'b1; cmp_wr_data = 32'd50; tick_en = 1'b1;
        step();
        idle_inputs();
        check("R11", "count written", count_q, 32'd50);
        check("R11", "compare written", compare_q, 32'd50);
        check("R11", "no pend same edge", {31'd0, timer_pend}, 32'd0);
        step();
        check("R11", "match on new values", {31'd0, timer_pend}, 32'd1);

        // R10: line follows select while pending
        for (int s = 0; s < 8; s++) begin
            irq_sel = 3'(s);
            #1;
            check("R10", $sformatf("line for select %0d", s), {24'd0, irq_lines}, 32'(1 << s));
        end

        // R1: reset while pending
        do_reset();

        summary();
        $finish;
    end
endmodule